// File: doc/BRIEF.md
# Converter Parallel Read Controller

This block sits on the host side of a 16-bit parallel bus that connects to a delta-sigma converter. It drives the active-low chip select and read/write strobe, and it only ever listens on the data lines. In normal mode it waits for the converter to announce a result with a low pulse on the data-ready line. It then runs two timed read cycles, joins the two words into a 24-bit sample and a 7-bit status field, and presents them on a valid/ready output. A data-ready announcement that lands while the read sequence is in progress marks that sample as bad.

In streaming mode the controller holds both strobes low for as long as the mode input stays high. On every return of data-ready to high it captures one bus word into a small FIFO, which drains through a second valid/ready output. The mode input is looked at only while the controller is idle. An asynchronous active-low reset clears the block and is released to the logic through a two-stage synchronizer.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, cs_n_o and rdwr_n_o are high, idle_o is high, smp_valid_o and str_valid_o are low, and smp_data_o, smp_status_o and smp_bad_o are zero.
- R2: In normal mode (mode_stream_i = 0), a falling edge of drdy_n_i seen while idle starts a read. From the next cycle cs_n_o and rdwr_n_o are both low for RD_LOW_CLKS cycles.
- R3: The bus is sampled on the clock edge that closes the last low cycle of each read strobe, and never earlier, so that the bus has time to turn on.
- R4: Between the two reads, both strobes are high for exactly GAP_CLKS cycles. The second low phase then lasts RD_LOW_CLKS cycles, after which the controller is idle.
- R5: smp_data_o[23:8] is the first word and smp_data_o[7:0] is bits 15:8 of the second word. smp_status_o[6:0] is bits 7:1 of the second word: bit 6 data-valid, bit 5 overrange, bit 4 filter-settling, bit 3 low-power, bit 2 filter-ok, bit 1 coefficient-load-ok, bit 0 calibrated. Bit 0 of the second word is discarded.
- R6: A falling edge of drdy_n_i in any cycle from the first low strobe cycle through the last cycle of the second read sets smp_bad_o for that sample, and that edge does not start a new read.
- R7: smp_valid_o and the sample stay unchanged until smp_ready_i is high at a clock edge. A read that completes while a sample is still waiting replaces it.
- R8: bus_oe_o is always low and bus_d_o is always zero: the controller never drives the data lines.
- R9: mode_stream_i is acted on only while idle. A change during a normal read sequence has no effect until that sequence has finished.
- R10: When idle with mode_stream_i = 1, both strobes go low from the next cycle and stay low while the mode stays high. They return high in the cycle after the mode is seen low.
- R11: In streaming mode, the bus word present at the first clock edge where drdy_n_i is high after being low is pushed into the FIFO. Words leave in arrival order on str_data_o under str_valid_o/str_ready_i.
- R12: When the FIFO holds FIFO_DEPTH words and is not popped in that cycle, an arriving word is dropped, and the stored words are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_stream_i | input | 1 | 0 selects the two-read mode, 1 selects streaming |
| drdy_n_i | input | 1 | Active-low data-ready from the converter |
| bus_d_i | input | 16 | Data lines as seen at the pins |
| bus_d_o | output | 16 | Data value for the pins, always zero |
| bus_oe_o | output | 1 | Pin output enable, always low |
| cs_n_o | output | 1 | Active-low chip select |
| rdwr_n_o | output | 1 | Read/write strobe, low for read |
| idle_o | output | 1 | High when no read sequence or stream is active |
| smp_valid_o | output | 1 | Assembled sample available |
| smp_ready_i | input | 1 | Consumer accepts the sample |
| smp_data_o | output | 24 | Assembled conversion result |
| smp_status_o | output | 7 | Status bits from the second read |
| smp_bad_o | output | 1 | Data-ready arrived during the read sequence |
| str_valid_o | output | 1 | FIFO holds a streamed word |
| str_ready_i | input | 1 | Consumer takes the FIFO head |
| str_data_o | output | 16 | FIFO head word |

## Verification
The hardest case to reach is a second data-ready edge that lands in one particular cycle of the read sequence: the last strobe cycle of the first read, the single cycle where the gap ends, or the edge where the second word is captured. The stimulus sends a start pulse and then a second pulse after every delay from one to eleven cycles, so each cycle of the sequence and the first idle cycle after it are hit once. The bus value changes on every clock, so capturing on the wrong edge shows up as a wrong word. The FIFO-full drop is reached by holding str_ready_i low through more pulses than the FIFO can hold and then draining it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int WORD_W   = 16;
  localparam int SAMPLE_W = 24;
  localparam int STAT_W   = 7;
  localparam int LSB_W    = SAMPLE_W - WORD_W;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD1    = 3'd1,
    ST_GAP    = 3'd2,
    ST_RD2    = 3'd3,
    ST_STREAM = 3'd4
  } rd_state_e;
endpackage

// File: rtl/adc_rd_sync.sv
// Reset release synchronizer plus data-ready edge detection.
module adc_rd_sync (
  input  logic clk,
  input  logic rst_n_i,
  input  logic drdy_n_i,
  output logic rst_int_n_o,
  output logic fall_o,
  output logic rise_o
);
  logic [1:0] rst_pipe_q;
  logic       drdy_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_int_n_o = rst_pipe_q[1];

  always_ff @(posedge clk or negedge rst_int_n_o) begin
    if (!rst_int_n_o) begin
      drdy_q <= 1'b1;
    end else begin
      drdy_q <= drdy_n_i;
    end
  end

  assign fall_o = drdy_q & ~drdy_n_i;
  assign rise_o = ~drdy_q & drdy_n_i;
endmodule

// File: rtl/adc_rd_seq.sv
// Read sequencer: two-read assembly in normal mode, held strobes in streaming.
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int RD_LOW_CLKS = 3,
  parameter int GAP_CLKS    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_stream_i,
  input  logic                fall_i,
  input  logic                rise_i,
  input  logic [WORD_W-1:0]   bus_d_i,
  output logic                cs_n_o,
  output logic                rdwr_n_o,
  output logic                idle_o,
  output logic                cmpl_o,
  output logic [SAMPLE_W-1:0] cmpl_data_o,
  output logic [STAT_W-1:0]   cmpl_stat_o,
  output logic                cmpl_bad_o,
  output logic                push_o,
  output logic [WORD_W-1:0]   push_data_o
);
  localparam int CNT_MAX = (RD_LOW_CLKS > GAP_CLKS) ? RD_LOW_CLKS : GAP_CLKS;
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_LOW_CLKS - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CLKS - 1);

  rd_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] word1_q;
  logic              word1_en;
  logic              bad_q, bad_d;
  logic              strobe_low;
  logic              rd_last, gap_last;

  assign rd_last  = (cnt_q == RD_LAST);
  assign gap_last = (cnt_q == GAP_LAST);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    bad_d    = bad_q;
    word1_en = 1'b0;
    cmpl_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (mode_stream_i) begin
          state_d = ST_STREAM;
        end else if (fall_i) begin
          state_d = ST_RD1;
          bad_d   = 1'b0;
        end
      end
      ST_RD1: begin
        if (fall_i) bad_d = 1'b1;
        if (rd_last) begin
          word1_en = 1'b1;
          state_d  = ST_GAP;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (fall_i) bad_d = 1'b1;
        if (gap_last) begin
          state_d = ST_RD2;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RD2: begin
        if (rd_last) begin
          cmpl_o  = 1'b1;
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          if (fall_i) bad_d = 1'b1;
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STREAM: begin
        cnt_d = '0;
        if (!mode_stream_i) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bad_q   <= bad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word1_q <= '0;
    end else if (word1_en) begin
      word1_q <= bus_d_i;
    end
  end

  assign strobe_low = (state_q == ST_RD1) || (state_q == ST_RD2) || (state_q == ST_STREAM);
  assign cs_n_o     = ~strobe_low;
  assign rdwr_n_o   = ~strobe_low;
  assign idle_o     = (state_q == ST_IDLE);

  assign cmpl_data_o = {word1_q, bus_d_i[WORD_W-1 -: LSB_W]};
  assign cmpl_stat_o = bus_d_i[STAT_W:1];
  assign cmpl_bad_o  = bad_q | fall_i;

  assign push_o      = (state_q == ST_STREAM) & rise_i;
  assign push_data_o = bus_d_i;
endmodule

// File: rtl/adc_rd_sample_reg.sv
// Holding register for assembled samples with a valid/ready handshake.
module adc_rd_sample_reg
  import adc_rd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic [STAT_W-1:0]   stat_i,
  input  logic                bad_i,
  input  logic                ready_i,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] data_o,
  output logic [STAT_W-1:0]   stat_o,
  output logic                bad_o
);
  logic valid_d;

  always_comb begin
    valid_d = valid_o;
    if (valid_o && ready_i) valid_d = 1'b0;
    if (load_i)             valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      stat_o <= '0;
      bad_o  <= 1'b0;
    end else if (load_i) begin
      data_o <= data_i;
      stat_o <= stat_i;
      bad_o  <= bad_i;
    end
  end
endmodule

// File: rtl/adc_rd_fifo.sv
// Small FIFO for streamed words; pushes into a full FIFO are dropped.
module adc_rd_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int PTR_W = (DEPTH < 2) ? 1 : $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_d;
  logic             push_ok, pop;

  assign valid_o = (count_o != '0);
  assign pop     = valid_o & ready_i;
  assign push_ok = push_i & (count_o != CNT_FULL);
  assign head_o  = mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_o;
    if (push_ok) begin
      wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop) begin
      rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push_ok, pop})
      2'b10:   count_d = count_o + 1'b1;
      2'b01:   count_d = count_o - 1'b1;
      default: count_d = count_o;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_o  <= count_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wr_ptr_q == PTR_W'(g))) begin
        mem_q[g] <= push_data_i;
      end
    end
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
// Top: host-side read controller for a parallel-bus delta-sigma converter.
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int RD_LOW_CLKS = 3,
  parameter int GAP_CLKS    = 2,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_stream_i,
  input  logic                drdy_n_i,
  input  logic [15:0]         bus_d_i,
  output logic [15:0]         bus_d_o,
  output logic                bus_oe_o,
  output logic                cs_n_o,
  output logic                rdwr_n_o,
  output logic                idle_o,
  output logic                smp_valid_o,
  input  logic                smp_ready_i,
  output logic [23:0]         smp_data_o,
  output logic [6:0]          smp_status_o,
  output logic                smp_bad_o,
  output logic                str_valid_o,
  input  logic                str_ready_i,
  output logic [15:0]         str_data_o
);
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);

  logic                rst_int_n;
  logic                fall, rise;
  logic                cmpl, cmpl_bad, push;
  logic [SAMPLE_W-1:0] cmpl_data;
  logic [STAT_W-1:0]   cmpl_stat;
  logic [WORD_W-1:0]   push_data;
  logic [FCNT_W-1:0]   fifo_count;

  assign bus_d_o  = '0;
  assign bus_oe_o = 1'b0;

  adc_rd_sync u_sync (
    .clk         (clk),
    .rst_n_i     (rst_n),
    .drdy_n_i    (drdy_n_i),
    .rst_int_n_o (rst_int_n),
    .fall_o      (fall),
    .rise_o      (rise)
  );

  adc_rd_seq #(
    .RD_LOW_CLKS (RD_LOW_CLKS),
    .GAP_CLKS    (GAP_CLKS)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .mode_stream_i (mode_stream_i),
    .fall_i        (fall),
    .rise_i        (rise),
    .bus_d_i       (bus_d_i),
    .cs_n_o        (cs_n_o),
    .rdwr_n_o      (rdwr_n_o),
    .idle_o        (idle_o),
    .cmpl_o        (cmpl),
    .cmpl_data_o   (cmpl_data),
    .cmpl_stat_o   (cmpl_stat),
    .cmpl_bad_o    (cmpl_bad),
    .push_o        (push),
    .push_data_o   (push_data)
  );

  adc_rd_sample_reg u_smp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (cmpl),
    .data_i  (cmpl_data),
    .stat_i  (cmpl_stat),
    .bad_i   (cmpl_bad),
    .ready_i (smp_ready_i),
    .valid_o (smp_valid_o),
    .data_o  (smp_data_o),
    .stat_o  (smp_status_o),
    .bad_o   (smp_bad_o)
  );

  adc_rd_fifo #(
    .DEPTH (FIFO_DEPTH),
    .W     (WORD_W)
  ) u_fifo (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .push_i      (push),
    .push_data_i (push_data),
    .ready_i     (str_ready_i),
    .valid_o     (str_valid_o),
    .head_o      (str_data_o),
    .count_o     (fifo_count)
  );
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int FIFO_DEPTH = 4,
  parameter int FCNT_W     = 3
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              mode_stream_i,
  input logic              drdy_n_i,
  input logic              cs_n_o,
  input logic              rdwr_n_o,
  input logic              idle_o,
  input logic              smp_valid_o,
  input logic              smp_ready_i,
  input logic [23:0]       smp_data_o,
  input logic              str_valid_o,
  input logic              str_ready_i,
  input logic [15:0]       str_data_o,
  input logic [FCNT_W-1:0] fifo_count
);
  p_start_read_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    idle_o && !mode_stream_i && $fell(drdy_n_i) |=> !cs_n_o && !rdwr_n_o);

  p_hold_sample_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    smp_valid_o && !smp_ready_i |=> smp_valid_o);

  p_keep_data_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    smp_valid_o && !smp_ready_i && cs_n_o |=> $stable(smp_data_o));

  p_stream_enter_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    idle_o && mode_stream_i |=> !cs_n_o && !rdwr_n_o);

  p_hold_stream_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    str_valid_o && !str_ready_i |=> str_valid_o && $stable(str_data_o));

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    fifo_count <= FCNT_W'(FIFO_DEPTH));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .FCNT_W     (FCNT_W)
) u_chk (
  .clk           (clk),
  .rst_int_n     (rst_int_n),
  .mode_stream_i (mode_stream_i),
  .drdy_n_i      (drdy_n_i),
  .cs_n_o        (cs_n_o),
  .rdwr_n_o      (rdwr_n_o),
  .idle_o        (idle_o),
  .smp_valid_o   (smp_valid_o),
  .smp_ready_i   (smp_ready_i),
  .smp_data_o    (smp_data_o),
  .str_valid_o   (str_valid_o),
  .str_ready_i   (str_ready_i),
  .str_data_o    (str_data_o),
  .fifo_count    (fifo_count)
);

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;
  localparam int RDL = 3;
  localparam int GAP = 2;
  localparam int DEP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        drdy_n = 1'b1;
  logic [15:0] bus_d = 16'h0000;
  logic        smp_ready = 1'b1;
  logic        str_ready = 1'b1;

  logic [15:0] bus_d_o;
  logic        bus_oe, cs_n, rdwr_n, idle;
  logic        smp_valid, smp_bad, str_valid;
  logic [23:0] smp_data;
  logic [6:0]  smp_status;
  logic [15:0] str_data;

  int n_cmp = 0;
  int n_bad = 0;
  int unsigned bcyc = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  adc_rd_ctrl #(.RD_LOW_CLKS(RDL), .GAP_CLKS(GAP), .FIFO_DEPTH(DEP)) u_adc_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_stream_i(mode), .drdy_n_i(drdy_n),
    .bus_d_i(bus_d), .bus_d_o(bus_d_o), .bus_oe_o(bus_oe),
    .cs_n_o(cs_n), .rdwr_n_o(rdwr_n), .idle_o(idle),
    .smp_valid_o(smp_valid), .smp_ready_i(smp_ready), .smp_data_o(smp_data),
    .smp_status_o(smp_status), .smp_bad_o(smp_bad),
    .str_valid_o(str_valid), .str_ready_i(str_ready), .str_data_o(str_data)
  );

  // Reference model: 0 idle, 1 first read, 2 gap, 3 second read, 4 streaming
  int          m_st;
  int          m_cnt;
  logic [15:0] m_w1;
  bit          m_bad, m_ov, m_obad, m_dq, m_s0, m_s1;
  logic [23:0] m_od;
  logic [6:0]  m_ost;
  logic [15:0] m_q[$];

  function automatic void model_clear();
    m_st = 0; m_cnt = 0; m_w1 = '0; m_bad = 0; m_ov = 0; m_obad = 0;
    m_od = '0; m_ost = '0; m_dq = 1; m_q.delete();
  endfunction

  always @(posedge clk) begin
    bit f, r, full, s1_pre;
    logic [15:0] b;
    b = bus_d;
    s1_pre = m_s1;
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; model_clear();
    end else begin
      if (!s1_pre) begin
        model_clear();
      end else begin
        f = m_dq && !drdy_n;
        r = !m_dq && drdy_n;
        full = (m_q.size() == DEP);
        if (m_ov && smp_ready) m_ov = 0;
        if (m_q.size() > 0 && str_ready) void'(m_q.pop_front());
        if (m_st == 4 && r && !full) m_q.push_back(b);
        case (m_st)
          0: if (mode) m_st = 4; else if (f) begin m_st = 1; m_cnt = 0; m_bad = 0; end
          1: begin
               if (f) m_bad = 1;
               if (m_cnt == RDL - 1) begin m_w1 = b; m_st = 2; m_cnt = 0; end
               else m_cnt++;
             end
          2: begin
               if (f) m_bad = 1;
               if (m_cnt == GAP - 1) begin m_st = 3; m_cnt = 0; end
               else m_cnt++;
             end
          3: begin
               if (m_cnt == RDL - 1) begin
                 m_ov = 1; m_od = {m_w1, b[15:8]}; m_ost = b[7:1];
                 m_obad = m_bad | f; m_st = 0; m_cnt = 0;
               end else begin
                 if (f) m_bad = 1;
                 m_cnt++;
               end
             end
          default: if (!mode) m_st = 0;
        endcase
        m_dq = drdy_n;
      end
      m_s1 = m_s0; m_s0 = 1;
    end
    cmp_on = 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      logic exp_low;
      exp_low = (m_st == 1) || (m_st == 3) || (m_st == 4);
      chk("R2 R4 R10 chip select", {31'd0, cs_n}, {31'd0, !exp_low});
      chk("R2 R4 R10 read strobe", {31'd0, rdwr_n}, {31'd0, !exp_low});
      chk("R1 R9 idle", {31'd0, idle}, {31'd0, m_st == 0});
      chk("R8 bus enable", {31'd0, bus_oe}, 32'd0);
      chk("R8 bus value", {16'd0, bus_d_o}, 32'd0);
      chk("R7 sample valid", {31'd0, smp_valid}, {31'd0, m_ov});
      chk("R3 R5 sample data", {8'd0, smp_data}, {8'd0, m_od});
      chk("R5 status", {25'd0, smp_status}, {25'd0, m_ost});
      chk("R6 bad flag", {31'd0, smp_bad}, {31'd0, m_obad});
      chk("R11 stream valid", {31'd0, str_valid}, {31'd0, m_q.size() > 0});
      if (m_q.size() > 0) chk("R11 R12 stream data", {16'd0, str_data}, {16'd0, m_q[0]});
    end
  end

  // Bus value changes every cycle so a wrong capture edge is visible.
  always @(negedge clk) begin
    bcyc++;
    bus_d = bcyc[15:0] * 16'h9E37 ^ 16'h5A5A;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int low);
    drdy_n = 1'b0;
    tick(low);
    drdy_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1..all actual=running expected=finished");
    finish_run();
  end

  initial begin
    tick(5);
    // R1: directed reset-state check
    chk("R1 reset cs_n", {31'd0, cs_n}, 32'd1);
    chk("R1 reset valid", {30'd0, smp_valid, str_valid}, 32'd0);
    rst_n = 1'b1;
    tick(6);
    // R2 R3 R4 R5: plain reads with different pulse widths
    for (int i = 1; i <= 4; i++) begin
      pulse(i);
      tick(14);
    end
    // R6: second pulse at every offset through the sequence and just after it
    for (int k = 1; k <= 11; k++) begin
      pulse(1);
      tick(k - 1);
      pulse(1);
      tick(16);
    end
    // R7: consumer stalls, second completion replaces the first
    smp_ready = 1'b0;
    pulse(2); tick(14);
    pulse(2); tick(14);
    smp_ready = 1'b1; tick(2);
    for (int i = 0; i < 6; i++) begin
      smp_ready = i[0];
      pulse(1); tick(11);
    end
    smp_ready = 1'b1;
    // R9: mode raised during a read waits for idle
    pulse(1); tick(2);
    mode = 1'b1; tick(6);
    mode = 1'b0; tick(3);
    pulse(1); tick(1);
    mode = 1'b1; tick(1);
    mode = 1'b0; tick(12);
    // R10 R11: streaming with varied pulse widths and spacing
    mode = 1'b1; tick(3);
    for (int i = 0; i < 8; i++) begin
      pulse(1 + (i % 3));
      tick(1 + (i % 4));
    end
    // R12: fill past depth while stalled, then drain
    str_ready = 1'b0;
    for (int i = 0; i < DEP + 3; i++) begin
      pulse(1); tick(2);
    end
    tick(3);
    str_ready = 1'b1; tick(8);
    // R11: pop and push in the same cycle region
    for (int i = 0; i < 6; i++) begin
      str_ready = i[0];
      pulse(1); tick(1);
    end
    str_ready = 1'b1; tick(6);
    // R10: leave streaming, then normal reads again
    mode = 1'b0; tick(4);
    for (int i = 0; i < 3; i++) begin
      pulse(2); tick(13);
    end
    tick(4);
    finish_run();
  end
endmodule